// File: doc/BRIEF.md
# Resonant Actuator Drive-Phase Sequencer

This block sets the phase of an H-bridge that drives a linear resonant actuator whose on/off command is a level enable. A rising enable starts a high-power start-up phase of programmable length. A normal drive phase follows and lasts as long as enable stays high. When enable drops, an optional brake phase damps the moving mass. The brake lasts as long as the burst that came before it, but never more than a fixed cap (30 ms by default). A downstream bridge driver takes the two-bit phase code and a polarity bit. The polarity bit flips every half resonance period while the actuator is driven.

All timing is counted in ticks of an internal prescaler (`TICK_DIV` clocks per tick). The prescaler restarts whenever the phase changes, so every phase length is an exact number of ticks from its own entry. The start-up length, half period and brake enable are latched on the accepted enable edge and hold for the whole burst. An active-low standby input forces the block idle. After standby is released, enable is ignored for a guard time (200 µs by default).

Top module: `lra_drive_sequencer`

## Requirements
- R1: While reset or standby is active, and whenever the phase is off, `phase_o` reads 0 (off) and `polarity_o` reads 0.
- R2: An accepted enable rising edge gives phase 1 (start-up) on the next clock, held for `cfg_startup_len` ticks, then phase 2 (drive). A start-up length of 0 goes straight to phase 2.
- R3: From the accepted rising edge, `polarity_o` starts at 1 and inverts every `cfg_half_period` ticks through start-up and drive.
- R4: Drive continues while enable is high. Once enable is low, the burst ends at the first clock on which at least two half periods (one resonance period) have passed since the accepted edge. A short pulse is therefore stretched to one period.
- R5: When braking is enabled, the burst end gives phase 3 (brake). It lasts N ticks, where N is the number of whole ticks between the accepted edge and the burst end, capped at `BRAKE_CAP`. Phase 0 follows.
- R6: During brake, `polarity_o` is the inverse of its value on the last drive clock and does not change.
- R7: When braking is disabled, the burst end goes directly to phase 0.
- R8: An enable rising edge during brake aborts the brake and starts a new burst (phase 1 or 2, polarity 1) on the next clock.
- R9: A low `standby_n` forces phase 0 on the next clock. For `GUARD_CYC` clocks after `standby_n` returns high, enable edges are ignored. An enable that is already high when the guard ends does not start a burst until it has been low again.
- R10: Start-up length, half period and brake enable are latched at the accepted rising edge. Changes to them during a burst have no effect on that burst.
- R11: The burst-time counter saturates at `BRAKE_CAP` ticks, so a burst of any length longer than the cap brakes for exactly `BRAKE_CAP` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_n | input | 1 | Active-low standby; low forces idle and re-arms the guard |
| en | input | 1 | Level enable, synchronous to clk |
| cfg_startup_len | input | SU_W | Start-up phase length in ticks |
| cfg_half_period | input | HP_W | Half resonance period in ticks |
| cfg_brake_en | input | 1 | 1 inserts a brake phase after each burst |
| phase_o | output | 2 | 0 off, 1 start-up, 2 drive, 3 brake |
| polarity_o | output | 1 | Bridge polarity |

## Verification
A wrong phase or tick counter shows at the ports within one tick, as a phase code that changes too early or too late. A wrong burst count shows only later, as a brake phase of the wrong length that ends too soon or too late. A wrong half-period counter shows as a polarity flip at the wrong clock, inside the first half period. The bench therefore compares phase and polarity on every clock of every burst against an arithmetic model. Latching, guard and standby faults show as a start-up that appears when it should not, or is missing when it should appear.

// File: rtl/lra_seq_pkg.sv
package lra_seq_pkg;

    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,
        PH_STARTUP = 2'd1,
        PH_DRIVE   = 2'd2,
        PH_BRAKE   = 2'd3
    } phase_e;

endpackage

// File: rtl/lra_tick_gen.sv
module lra_tick_gen #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } tick_t;

    tick_t d, q;

    assign tick = (q.pre == LAST);

    always_comb begin
        d = q;
        if (restart || tick) begin
            d.pre = '0;
        end else begin
            d.pre = q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lra_standby_guard.sv
module lra_standby_guard #(
    parameter int GUARD_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_n,
    output logic ready
);
    localparam int CNT_W = (GUARD_CYC > 0) ? $clog2(GUARD_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(GUARD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } guard_t;

    guard_t d, q;

    assign ready = (q.cnt == '0);

    always_comb begin
        d = q;
        if (!standby_n) begin
            d.cnt = LOAD;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= LOAD;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lra_polarity_gen.sv
module lra_polarity_gen #(
    parameter int HP_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            clear,
    input  logic            start,
    input  logic            invert,
    input  logic            run,
    input  logic [HP_W-1:0] half_period,
    output logic            polarity
);
    typedef struct packed {
        logic [HP_W-1:0] hp;
        logic            pol;
    } pol_t;

    pol_t d, q;

    assign polarity = q.pol;

    always_comb begin
        d = q;
        if (clear) begin
            d.pol = 1'b0;
            d.hp  = '0;
        end else if (start) begin
            d.pol = 1'b1;
            d.hp  = '0;
        end else if (invert) begin
            d.pol = ~q.pol;
            d.hp  = '0;
        end else if (run && tick) begin
            if (q.hp == half_period - HP_W'(1)) begin
                d.pol = ~q.pol;
                d.hp  = '0;
            end else begin
                d.hp = q.hp + HP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lra_drive_sequencer.sv
module lra_drive_sequencer
    import lra_seq_pkg::*;
#(
    parameter int TICK_DIV  = 1000,
    parameter int BRAKE_CAP = 3000,
    parameter int GUARD_CYC = 20000,
    parameter int SU_W      = 8,
    parameter int HP_W      = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            standby_n,
    input  logic            en,
    input  logic [SU_W-1:0] cfg_startup_len,
    input  logic [HP_W-1:0] cfg_half_period,
    input  logic            cfg_brake_en,
    output logic [1:0]      phase_o,
    output logic            polarity_o
);
    localparam int BURST_W = $clog2(BRAKE_CAP + 1);
    localparam int TMR_W   = (SU_W > BURST_W) ? SU_W : BURST_W;
    localparam int CMP_W   = (BURST_W > HP_W + 1) ? BURST_W : HP_W + 1;
    localparam logic [BURST_W-1:0] CAP_V = BURST_W'(BRAKE_CAP);

    typedef struct packed {
        phase_e             phase;
        logic [SU_W-1:0]    su_len;
        logic [HP_W-1:0]    half;
        logic               brk_en;
        logic [BURST_W-1:0] burst;
        logic [TMR_W-1:0]   tmr;
        logic               en_prev;
    } seq_t;

    seq_t d, q;

    logic               tick;
    logic               ready;
    logic               restart;
    logic               pol_clear, pol_start, pol_invert, pol_run;
    logic               rise;
    logic [BURST_W-1:0] burst_inc;
    logic [TMR_W-1:0]   tmr_inc;
    logic [CMP_W-1:0]   min_ticks;
    logic               min_ok;

    lra_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    lra_standby_guard #(.GUARD_CYC(GUARD_CYC)) i_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_n (standby_n),
        .ready     (ready)
    );

    lra_polarity_gen #(.HP_W(HP_W)) i_pol (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .clear       (pol_clear),
        .start       (pol_start),
        .invert      (pol_invert),
        .run         (pol_run),
        .half_period (q.half),
        .polarity    (polarity_o)
    );

    // Next-state computation for the phase sequencer
    always_comb begin
        d          = q;
        pol_clear  = 1'b0;
        pol_start  = 1'b0;
        pol_invert = 1'b0;
        pol_run    = 1'b0;

        d.en_prev = en;
        rise      = en && !q.en_prev && ready;
        burst_inc = (tick && (q.burst != CAP_V)) ? q.burst + BURST_W'(1) : q.burst;
        tmr_inc   = tick ? q.tmr + TMR_W'(1) : q.tmr;
        min_ticks = CMP_W'({q.half, 1'b0});
        min_ok    = (CMP_W'(burst_inc) >= min_ticks) || (burst_inc == CAP_V);

        if (!standby_n) begin
            d.phase   = PH_OFF;
            d.burst   = '0;
            d.tmr     = '0;
            pol_clear = 1'b1;
        end else begin
            unique case (q.phase)
                PH_OFF, PH_BRAKE: begin
                    if (rise) begin
                        d.su_len  = cfg_startup_len;
                        d.half    = cfg_half_period;
                        d.brk_en  = cfg_brake_en;
                        d.burst   = '0;
                        d.tmr     = '0;
                        pol_start = 1'b1;
                        d.phase   = (cfg_startup_len == '0) ? PH_DRIVE : PH_STARTUP;
                    end else if (q.phase == PH_BRAKE) begin
                        d.tmr = tmr_inc;
                        if (tick && (q.tmr == TMR_W'(q.burst) - TMR_W'(1))) begin
                            d.phase   = PH_OFF;
                            d.tmr     = '0;
                            pol_clear = 1'b1;
                        end
                    end
                end
                PH_STARTUP, PH_DRIVE: begin
                    d.burst = burst_inc;
                    if (!en && min_ok) begin
                        d.tmr = '0;
                        if (q.brk_en && (burst_inc != '0)) begin
                            d.phase    = PH_BRAKE;
                            pol_invert = 1'b1;
                        end else begin
                            d.phase   = PH_OFF;
                            pol_clear = 1'b1;
                        end
                    end else begin
                        pol_run = 1'b1;
                        if (q.phase == PH_STARTUP) begin
                            d.tmr = tmr_inc;
                            if (tick && (q.tmr == TMR_W'(q.su_len) - TMR_W'(1))) begin
                                d.phase = PH_DRIVE;
                                d.tmr   = '0;
                            end
                        end
                    end
                end
                default: d.phase = PH_OFF;
            endcase
        end

        restart = (d.phase != q.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_OFF;
        end else begin
            q <= d;
        end
    end

    assign phase_o = q.phase;

endmodule

module lra_seq_chk
    import lra_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       standby_n,
    input logic       en,
    input logic [1:0] phase_o,
    input logic       polarity_o
);
    // R1
    off_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_OFF) |-> !polarity_o);

    // R9
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> (phase_o == PH_OFF));

    // R4
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_o == PH_STARTUP || phase_o == PH_DRIVE) && en && standby_n)
        |=> (phase_o == PH_STARTUP || phase_o == PH_DRIVE));

    // R6
    brake_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_BRAKE && $past(phase_o) == PH_BRAKE) |-> $stable(polarity_o));

    // R5
    brake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_BRAKE && $past(phase_o) != PH_BRAKE)
        |-> ($past(phase_o) == PH_STARTUP || $past(phase_o) == PH_DRIVE));

    // R8
    brake_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_BRAKE && en && !$past(en) && standby_n)
        |=> (phase_o == PH_STARTUP || phase_o == PH_DRIVE));
endmodule

bind lra_drive_sequencer lra_seq_chk i_lra_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby_n  (standby_n),
    .en         (en),
    .phase_o    (phase_o),
    .polarity_o (polarity_o)
);

// File: tb/test_lra_drive_sequencer.sv
module test_lra_drive_sequencer;
    localparam int D     = 2;
    localparam int CAP   = 20;
    localparam int GUARD = 10;
    localparam int SUW   = 4;
    localparam int HPW   = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           standby_n = 1'b1;
    logic           en = 1'b0;
    logic [SUW-1:0] cfg_startup_len = '0;
    logic [HPW-1:0] cfg_half_period = 4'd1;
    logic           cfg_brake_en = 1'b0;
    logic [1:0]     phase_o;
    logic           polarity_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lra_drive_sequencer #(
        .TICK_DIV  (D),
        .BRAKE_CAP (CAP),
        .GUARD_CYC (GUARD),
        .SU_W      (SUW),
        .HP_W      (HPW)
    ) i_lra_drive_sequencer (
        .clk             (clk),
        .rst_n           (rst_n),
        .standby_n       (standby_n),
        .en              (en),
        .cfg_startup_len (cfg_startup_len),
        .cfg_half_period (cfg_half_period),
        .cfg_brake_en    (cfg_brake_en),
        .phase_o         (phase_o),
        .polarity_o      (polarity_o)
    );

    // value compared = phase * 2 + polarity
    task automatic check(input string tag, input int exp_v);
        int act_v;
        act_v = int'(phase_o) * 2 + int'(polarity_o);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s: actual phase/pol %0d/%0d expected %0d/%0d at %0t",
                     tag, act_v / 2, act_v % 2, exp_v / 2, exp_v % 2, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // One burst: rise, hc clocks high, then model every clock until idle.
    task automatic run_burst(input int L, input int H, input bit brk, input int hc,
                             input int stop_n, input bit ab, input bit scr);
        int hd, e, b, total, ep, epol;
        bit lastp;
        string tag;
        hd = H * D;
        e  = (hc > 2 * hd) ? hc : 2 * hd;
        b  = e / D;
        if (b > CAP) b = CAP;
        total = e + (brk ? b * D : 0) + 3;
        if (stop_n >= 0) total = stop_n + 1;
        lastp = (((e - 1) / hd) % 2) == 0;
        @(negedge clk);
        cfg_startup_len = SUW'(L);
        cfg_half_period = HPW'(H);
        cfg_brake_en    = brk;
        en              = 1'b1;
        for (int n = 0; n < total; n++) begin
            @(negedge clk);
            if (n < e) begin
                ep   = (n < L * D) ? 1 : 2;
                epol = (((n / hd) % 2) == 0) ? 1 : 0;
                if (ep == 1) tag = "R2";
                else if (n >= hc) tag = "R4";
                else tag = "R3";
            end else if (brk && n < e + b * D) begin
                ep   = 3;
                epol = lastp ? 0 : 1;
                if (n == e) tag = "R6";
                else if (b == CAP) tag = "R11";
                else tag = "R5";
            end else begin
                ep   = 0;
                epol = 0;
                if (!brk) tag = "R7";
                else if (b == CAP) tag = "R11";
                else tag = "R5";
            end
            if (n == 0 && ab) tag = "R8";
            else if (scr) tag = "R10";
            check(tag, ep * 2 + epol);
            if (scr && n == 0) begin
                cfg_startup_len = 4'd15;
                cfg_half_period = 4'd15;
                cfg_brake_en    = ~brk;
            end
            if (n + 1 == hc) en = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual not finished expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int hcs[6];
        hcs = '{1, 5, 9, 14, 40, 60};
        repeat (3) @(negedge clk);
        check("R1", 0);                      // reset state
        rst_n = 1'b1;
        repeat (GUARD + 3) @(negedge clk);
        check("R1", 0);                      // idle after guard

        // Sweep start-up length, half period, burst length, brake enable
        for (int l = 0; l < 3; l++) begin
            for (int h = 1; h <= 3; h++) begin
                for (int k = 0; k < 6; k++) begin
                    for (int bk = 0; bk < 2; bk++) begin
                        run_burst((l == 2) ? 3 : l, h, bit'(bk), hcs[k], -1, 1'b0, 1'b0);
                    end
                end
            end
        end

        // R8: re-enable in the middle of a brake phase
        run_burst(1, 1, 1'b1, 10, 14, 1'b0, 1'b0);
        run_burst(2, 2, 1'b1, 12, -1, 1'b1, 1'b0);

        // R10: configuration changed during the burst
        run_burst(2, 3, 1'b1, 20, -1, 1'b0, 1'b1);
        run_burst(1, 2, 1'b0, 3, -1, 1'b0, 1'b1);

        // R9: standby mid-burst, guard after release
        @(negedge clk);
        cfg_startup_len = 4'd1;
        cfg_half_period = 4'd2;
        cfg_brake_en    = 1'b1;
        en              = 1'b1;
        repeat (6) @(negedge clk);
        standby_n = 1'b0;
        @(negedge clk);
        check("R9", 0);
        repeat (2) @(negedge clk);
        check("R9", 0);
        standby_n = 1'b1;
        for (int n = 0; n < GUARD + 6; n++) begin
            @(negedge clk);
            check("R9", 0);
            if (n == 1) en = 1'b0;
            if (n == 3) en = 1'b1;
        end
        en = 1'b0;
        @(negedge clk);
        check("R9", 0);
        en = 1'b1;
        @(negedge clk);
        check("R9", 1 * 2 + 1);              // start-up, polarity 1
        en = 1'b0;
        repeat (40) @(negedge clk);
        check("R9", 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule